// File: doc/BRIEF.md
# Power-Down and Calibration Sequencer

This controller decides when a two-channel converter (channels I and Q) is awake, asleep or calibrating. It takes a global sleep request, a sleep request for the Q channel only, a manual calibration request and a done handshake from a separate calibration engine. It drives a one-cycle calibration launch pulse, per-channel calibration enables, per-channel power-down controls, per-channel data-bus output enables, a weak-low control for the clock and range-flag outputs, and a data-valid flag. The calibration algorithm and the analog power switches are outside this block. The block only enforces the ordering between sleep and calibration.

Five states make up the sequencer. `ST_INIT` is entered on power-on reset. The chip stays asleep there until the sleep request is low. The move `INIT->CAL` then launches the power-on calibration. `ST_CAL` waits for the done handshake. A sleep request during calibration is held back. On done, `CAL->DOWN` is taken if sleep is requested, and `CAL->RUN` otherwise. `ST_DOWN` is sleep, and it takes `DOWN->FLUSH` when the request falls. `ST_FLUSH` hides the stale pipeline for a set number of cycles, then takes `FLUSH->RUN`. If sleep returns during the flush, it takes `FLUSH->DOWN`. `ST_RUN` is normal operation. A new rising edge on the manual request takes `RUN->CAL`, and a sleep request takes `RUN->DOWN`.

Top module: `pdcal_seq`

## Requirements
- R1: While `por_n` is low, the block is in the asleep state. Both sleep outputs are 1, both bus enables are 0, `side_weak_low` is 1, and `cal_go` is 0. After release, the power-on calibration starts on the first clock edge at which `sleep_req` is low. It does not start while `sleep_req` stays high.
- R2: `cal_go` is high for exactly one cycle: the first cycle in which `cal_en_i` is high.
- R3: A `sleep_req` that rises during calibration does not end the calibration. The block stays calibrating until `cal_done` is sampled high, and then goes asleep on that edge.
- R4: A rising edge of `man_cal_req` starts a calibration only in the running state. An edge seen while asleep, flushing or calibrating is dropped and not kept for later. A request held high starts at most one calibration. The held-high value present at reset counts as no edge.
- R5: `q_sleep_req` high forces `sleep_q`=1 and `bus_oe_q`=0 in every state, and leaves `sleep_i` and `bus_oe_i` unchanged.
- R6: During calibration, `cal_en_i`=1, and `cal_en_q` equals the inverse of `q_sleep_req`.
- R7: While asleep (reset-idle or sleep state), both bus enables are 0 and `side_weak_low` is 1. In every other state `side_weak_low` is 0 and `bus_oe_i` is 1.
- R8: When `sleep_req` falls in the sleep state, the block flushes for exactly `FLUSH_CYCLES` cycles. During the flush, buses are enabled and `out_valid`=0. `out_valid` then goes to 1. A `sleep_req` during the flush returns the block to sleep on the next edge.
- R9: `out_valid` is 1 only in the running state: never during calibration, flush or sleep.
- R10: `cal_done` sampled high during calibration with `sleep_req` low moves the block to the running state on that edge, with `out_valid`=1 and no flush.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset indication, active low, asynchronous |
| sleep_req | input | 1 | Global power-down request |
| q_sleep_req | input | 1 | Power-down request for channel Q only |
| man_cal_req | input | 1 | Manual calibration request (edge-detected) |
| cal_done | input | 1 | Calibration engine has finished |
| cal_go | output | 1 | One-cycle calibration launch pulse |
| cal_en_i | output | 1 | Include channel I in calibration |
| cal_en_q | output | 1 | Include channel Q in calibration |
| sleep_i | output | 1 | Power-down control for channel I |
| sleep_q | output | 1 | Power-down control for channel Q |
| bus_oe_i | output | 1 | Data bus I output enable (0 = high impedance) |
| bus_oe_q | output | 1 | Data bus Q output enable (0 = high impedance) |
| side_weak_low | output | 1 | Drive the clock and range-flag outputs weakly low |
| out_valid | output | 1 | Output data is valid |

## Verification
The bench holds the sleep request high through reset. It checks that the power-on calibration waits, and that a manual edge seen meanwhile is neither obeyed nor remembered. A design that queued requests would launch a second calibration after wake-up. It raises sleep during a calibration and checks the deferral. A design that obeyed at once would cut the calibration short and show `cal_en_i` falling before `cal_done`. It times the wake-up flush to the exact cycle and interrupts a flush with a new sleep request, which catches an off-by-one flush counter or a flush that cannot be aborted. It also runs a calibration with Q asleep and holds a manual request high over several cycles, which catches a Q enable left on and a level-triggered launch.

// File: rtl/pdcal_pkg.sv
package pdcal_pkg;

    typedef enum logic [2:0] {
        ST_INIT  = 3'd0,
        ST_CAL   = 3'd1,
        ST_DOWN  = 3'd2,
        ST_FLUSH = 3'd3,
        ST_RUN   = 3'd4
    } pdcal_state_e;

endpackage

// File: rtl/pdcal_req_edge.sv
module pdcal_req_edge (
    input  logic clk,
    input  logic rst_n,
    input  logic req,
    output logic rise
);
    logic req_q;

    // previous value resets high so a level present at reset is no edge
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) req_q <= 1'b1;
        else        req_q <= req;
    end

    assign rise = req & ~req_q;
endmodule

// File: rtl/pdcal_flush_cnt.sv
module pdcal_flush_cnt #(
    parameter int unsigned CYCLES = 34
) (
    input  logic clk,
    input  logic rst_n,
    input  logic active,
    output logic done
);
    localparam int unsigned CW = $clog2(CYCLES + 1);

    logic [CW-1:0] cnt;

    assign done = active && (cnt == CW'(CYCLES - 1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       cnt <= '0;
        else if (!active) cnt <= '0;
        else if (!done)   cnt <= cnt + 1'b1;
    end
endmodule

// File: rtl/pdcal_seq.sv
module pdcal_seq #(
    parameter int unsigned FLUSH_CYCLES = 34
) (
    input  logic clk,
    input  logic por_n,
    input  logic sleep_req,
    input  logic q_sleep_req,
    input  logic man_cal_req,
    input  logic cal_done,
    output logic cal_go,
    output logic cal_en_i,
    output logic cal_en_q,
    output logic sleep_i,
    output logic sleep_q,
    output logic bus_oe_i,
    output logic bus_oe_q,
    output logic side_weak_low,
    output logic out_valid
);
    import pdcal_pkg::*;

    pdcal_state_e state, state_nxt;
    logic         man_rise;
    logic         flush_done;
    logic         cal_go_q;
    logic         asleep;

    pdcal_req_edge u_edge (
        .clk   (clk),
        .rst_n (por_n),
        .req   (man_cal_req),
        .rise  (man_rise)
    );

    pdcal_flush_cnt #(.CYCLES(FLUSH_CYCLES)) u_flush (
        .clk    (clk),
        .rst_n  (por_n),
        .active (state == ST_FLUSH),
        .done   (flush_done)
    );

    // state register
    always_ff @(posedge clk or negedge por_n) begin
        if (!por_n) begin
            state    <= ST_INIT;
            cal_go_q <= 1'b0;
        end else begin
            state    <= state_nxt;
            cal_go_q <= (state_nxt == ST_CAL) && (state != ST_CAL);
        end
    end

    // transitions
    always_comb begin
        state_nxt = state;
        unique case (state)
            ST_INIT:  if (!sleep_req) state_nxt = ST_CAL;
            ST_CAL:   if (cal_done)   state_nxt = sleep_req ? ST_DOWN : ST_RUN;
            ST_DOWN:  if (!sleep_req) state_nxt = ST_FLUSH;
            ST_FLUSH: begin
                if (sleep_req)       state_nxt = ST_DOWN;
                else if (flush_done) state_nxt = ST_RUN;
            end
            ST_RUN: begin
                if (sleep_req)     state_nxt = ST_DOWN;
                else if (man_rise) state_nxt = ST_CAL;
            end
            default:               state_nxt = ST_INIT;
        endcase
    end

    // outputs
    always_comb begin
        asleep        = (state == ST_INIT) || (state == ST_DOWN);
        cal_go        = cal_go_q;
        cal_en_i      = (state == ST_CAL);
        cal_en_q      = (state == ST_CAL) && !q_sleep_req;
        sleep_i       = asleep;
        sleep_q       = asleep || q_sleep_req;
        bus_oe_i      = !asleep;
        bus_oe_q      = !(asleep || q_sleep_req);
        side_weak_low = asleep;
        out_valid     = (state == ST_RUN);
    end
endmodule

// File: rtl/pdcal_seq_chk.sv
module pdcal_seq_chk (
    input logic clk,
    input logic por_n,
    input logic sleep_req,
    input logic q_sleep_req,
    input logic cal_done,
    input logic cal_go,
    input logic cal_en_i,
    input logic cal_en_q,
    input logic sleep_i,
    input logic bus_oe_i,
    input logic bus_oe_q,
    input logic side_weak_low,
    input logic out_valid
);
    // R2
    cal_go_single_chk: assert property (@(posedge clk) disable iff (!por_n)
        cal_go |=> !cal_go);

    // R3
    cal_hold_chk: assert property (@(posedge clk) disable iff (!por_n)
        (cal_en_i && !cal_done) |=> cal_en_i);

    // R4
    asleep_no_go_chk: assert property (@(posedge clk) disable iff (!por_n)
        (sleep_i && sleep_req) |=> !cal_go);

    // R5
    q_sleep_oe_chk: assert property (@(posedge clk) disable iff (!por_n)
        q_sleep_req |-> !bus_oe_q);

    // R6
    q_cal_excl_chk: assert property (@(posedge clk) disable iff (!por_n)
        (cal_en_i && q_sleep_req) |-> !cal_en_q);

    // R7
    weak_low_hiz_chk: assert property (@(posedge clk) disable iff (!por_n)
        side_weak_low |-> (!bus_oe_i && !bus_oe_q));

    // R8
    wake_not_valid_chk: assert property (@(posedge clk) disable iff (!por_n)
        $rose(bus_oe_i) |-> !out_valid);

    // R9
    valid_only_run_chk: assert property (@(posedge clk) disable iff (!por_n)
        out_valid |-> (!cal_en_i && !sleep_i));
endmodule

bind pdcal_seq pdcal_seq_chk u_chk (
    .clk           (clk),
    .por_n         (por_n),
    .sleep_req     (sleep_req),
    .q_sleep_req   (q_sleep_req),
    .cal_done      (cal_done),
    .cal_go        (cal_go),
    .cal_en_i      (cal_en_i),
    .cal_en_q      (cal_en_q),
    .sleep_i       (sleep_i),
    .bus_oe_i      (bus_oe_i),
    .bus_oe_q      (bus_oe_q),
    .side_weak_low (side_weak_low),
    .out_valid     (out_valid)
);

// File: tb/pdcal_seq_test.sv
`timescale 1ns/1ps
module pdcal_seq_test;
    localparam int unsigned FLUSH = 4;
    localparam int NV = 20;

    logic clk = 1'b0;
    logic por_n = 1'b0;
    logic sleep_req = 1'b0, q_sleep_req = 1'b0, man_cal_req = 1'b0, cal_done = 1'b0;
    logic cal_go, cal_en_i, cal_en_q, sleep_i, sleep_q, bus_oe_i, bus_oe_q;
    logic side_weak_low, out_valid;
    logic [8:0] obs;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2.5 clk = ~clk;

    pdcal_seq #(.FLUSH_CYCLES(FLUSH)) uut (
        .clk(clk), .por_n(por_n), .sleep_req(sleep_req), .q_sleep_req(q_sleep_req),
        .man_cal_req(man_cal_req), .cal_done(cal_done), .cal_go(cal_go),
        .cal_en_i(cal_en_i), .cal_en_q(cal_en_q), .sleep_i(sleep_i), .sleep_q(sleep_q),
        .bus_oe_i(bus_oe_i), .bus_oe_q(bus_oe_q), .side_weak_low(side_weak_low),
        .out_valid(out_valid)
    );

    // {go, en_i, en_q, sleep_i, sleep_q, oe_i, oe_q, weak, valid}
    assign obs = {cal_go, cal_en_i, cal_en_q, sleep_i, sleep_q,
                  bus_oe_i, bus_oe_q, side_weak_low, out_valid};

    localparam logic [8:0] O_SLEEP = 9'b000110010;
    localparam logic [8:0] O_GO    = 9'b111001100;
    localparam logic [8:0] O_CAL   = 9'b011001100;
    localparam logic [8:0] O_FLUSH = 9'b000001100;
    localparam logic [8:0] O_RUN   = 9'b000001101;
    localparam logic [8:0] O_RUNQ  = 9'b000011001;
    localparam logic [8:0] O_GOQ   = 9'b110011000;

    // {sleep_req, q_sleep_req, man_cal_req, cal_done, expected}
    localparam logic [12:0] VEC [NV] = '{
        {4'b1000, O_SLEEP},  // 0  R1 power-on cal held off
        {4'b1010, O_SLEEP},  // 1  R4 edge while asleep dropped
        {4'b0010, O_GO},     // 2  R1 R2 cal starts, held req no edge
        {4'b0000, O_CAL},    // 3  R2 pulse ends
        {4'b1000, O_CAL},    // 4  R3 sleep deferred
        {4'b1001, O_SLEEP},  // 5  R3 sleep after done
        {4'b1000, O_SLEEP},  // 6  R7
        {4'b1010, O_SLEEP},  // 7  R4 dropped edge
        {4'b0010, O_FLUSH},  // 8  R8 flush 1
        {4'b0000, O_FLUSH},  // 9  R8 flush 2
        {4'b0000, O_FLUSH},  // 10 R8 flush 3
        {4'b0000, O_FLUSH},  // 11 R8 flush 4
        {4'b0000, O_RUN},    // 12 R8 R9 valid
        {4'b0100, O_RUNQ},   // 13 R5 Q asleep only
        {4'b0110, O_GOQ},    // 14 R4 R6 cal without Q
        {4'b0111, O_RUNQ},   // 15 R10 done to run
        {4'b0010, O_RUN},    // 16 R4 held req no second cal
        {4'b1000, O_SLEEP},  // 17 R7 sleep from run
        {4'b0000, O_FLUSH},  // 18 R8 wake
        {4'b1000, O_SLEEP}   // 19 R8 flush aborted
    };

    function automatic string row_tag(int i);
        case (i)
            0:        return "R1";
            1, 7, 16: return "R4";
            2, 3:     return "R2";
            4, 5:     return "R3";
            6, 17:    return "R7";
            13:       return "R5";
            14:       return "R6";
            15:       return "R10";
            12:       return "R9";
            default:  return "R8";
        endcase
    endfunction

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic check(string tag, logic [8:0] got, logic [8:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %b expected %b", tag, got, exp);
        end
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (5000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    initial begin
        // R1 reset state, sleep low
        repeat (3) step();
        check("R1 reset", obs, O_SLEEP);
        por_n = 1'b1;
        step();
        check("R1 R2 power-on cal", obs, O_GO);
        step();
        check("R2 single pulse", obs, O_CAL);
        cal_done = 1'b1;
        step();
        check("R10 done to run", obs, O_RUN);
        cal_done = 1'b0;

        // reset again with sleep held high for the table
        sleep_req = 1'b1;
        #1 por_n = 1'b0;
        step();
        check("R1 reset asleep", obs, O_SLEEP);
        por_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            {sleep_req, q_sleep_req, man_cal_req, cal_done} = VEC[i][12:9];
            step();
            check(row_tag(i), obs, VEC[i][8:0]);
        end

        // R5: Q sleep while asleep keeps I unchanged
        q_sleep_req = 1'b1;
        step();
        check("R5 q asleep in sleep", obs, O_SLEEP);

        // R8 exact flush length with default-like wake, then R4 edge in flush dropped
        sleep_req = 1'b0; q_sleep_req = 1'b0; man_cal_req = 1'b0;
        step();
        check("R8 flush start", obs, O_FLUSH);
        man_cal_req = 1'b1;
        step();
        check("R4 edge in flush dropped", obs, O_FLUSH);
        step();
        step();
        check("R8 flush last", obs, O_FLUSH);
        step();
        check("R8 run after flush", obs, O_RUN);
        step();
        check("R4 no queued cal", obs, O_RUN);

        finish_run();
    end
endmodule